// File: doc/BRIEF.md
# Prescaled Compare Timer

A single timer channel for periodic ticks and one-shot timeouts. An input clock is divided by a programmable prescaler, and each prescaled tick advances a 24-bit up-counter. When the counter reaches the programmed compare value, it raises a sticky match flag. It then stays at the compare value for exactly one more tick before it returns to zero. In periodic mode counting continues. In one-shot mode the block drops its own run bit and leaves the counter parked at the compare value.

Software reaches the block through four word registers on a synchronous port: one write strobe, a 2-bit address and a combinational read. The registers are control (address 0), compare (address 1), count view (address 2) and status (address 3). The interrupt output is the match flag gated by an enable bit.

A three-state machine in the counting core sequences the counter:
- **ST_IDLE**: not counting. It moves to ST_COUNT when run is set, or to ST_HOLD if the counter already equals the compare value.
- **ST_COUNT**: advances on each tick. On the tick that makes the counter equal to the compare value, it moves to ST_HOLD (periodic) or back to ST_IDLE (one-shot, "done").
- **ST_HOLD**: holds the counter at the compare value. The next tick wraps the counter to zero and returns to ST_COUNT.

Clearing run sends either counting state to ST_IDLE. A counter reset sends every state to ST_IDLE.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset, control reads 0, compare reads 0xFFFFFF, count view reads 0, status reads 0 and `irq` is low.
- R2: A compare write stores `wdata[23:0]`; a value below 2 is stored as 2, and bits above 23 are ignored.
- R3: Control bits [6:0] hold the prescale value P. While counting, the counter advances once every P+1 clocks. The first advance comes P+2 clocks after the write edge that sets run (control bit 8).
- R4: In periodic mode (control bit 9 = 0), the counter steps 0,1,…,C, holds C for one tick, then wraps to 0, for a period of (C+1)(P+1) clocks. The match flag (status bit 0) sets on the edge where the counter becomes C.
- R5: In one-shot mode (control bit 9 = 1), the edge where the counter becomes C also clears run. The counter then stays at C and no further match occurs.
- R6: The match flag stays set until a status write with bit 0 = 1. A status write with bit 0 = 0 leaves it unchanged.
- R7: `irq` equals the match flag ANDed with the interrupt enable (control bit 10).
- R8: A control write with bit 12 set clears the prescaler, the counter and run at that write edge. Bit 12 reads back as 1 for the next cycle only.
- R9: While the live bit (control bit 11) is set, the count view follows the counter one cycle late. While it is clear, the view holds its last value.
- R10: A compare write while counting takes effect at the next comparison and leaves the prescaler phase unchanged.
- R11: Clearing run freezes the counter at its current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the prescaler input |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 control, 1 compare, 2 view, 3 status) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Match flag gated by interrupt enable |

## Verification
The bench sweeps every prescale value from 0 to 3 against compare values 2, 3 and 5. For each pair it checks the counter and the flag on every clock, against a closed-form model of tick count modulo C+1.

The corner cases it targets each expose a specific fault:
- A design that skipped the hold tick would show a period of C·(P+1).
- A design that restarted the prescaler on a compare write would match late.
- A one-shot that failed to clear run would wrap back to 0 and match again.
- A wrong clamp would store a compare of 0 or 1.
- A flag cleared by a zero write would drop early.

// File: rtl/tick_cmp_pkg.sv
package tick_cmp_pkg;
    localparam int REG_AW    = 2;
    localparam logic [REG_AW-1:0] A_CTRL = 2'd0;
    localparam logic [REG_AW-1:0] A_CMP  = 2'd1;
    localparam logic [REG_AW-1:0] A_VIEW = 2'd2;
    localparam logic [REG_AW-1:0] A_STAT = 2'd3;

    localparam int B_RUN     = 8;
    localparam int B_ONESHOT = 9;
    localparam int B_IE      = 10;
    localparam int B_LIVE    = 11;
    localparam int B_CLR     = 12;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_HOLD  = 2'd2
    } tmr_state_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PSC_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             active,
    input  logic [PSC_W-1:0] psc_val,
    output logic             tick
);
    logic [PSC_W-1:0] psc_cnt;

    assign tick = active && (psc_cnt >= psc_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               psc_cnt <= '0;
        else if (clr || !active)  psc_cnt <= '0;
        else if (tick)            psc_cnt <= '0;
        else                      psc_cnt <= psc_cnt + PSC_W'(1);
    end

    // R3: with a nonzero prescale value, ticks never come on adjacent clocks
    p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && psc_val != '0 && !clr && $stable(psc_val)) |=> !tick);
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tick_cmp_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             oneshot,
    input  logic             tick,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt,
    output logic             hit,
    output logic             done,
    output logic             counting
);
    tmr_state_e       state, state_n;
    logic [CNT_W-1:0] cnt_n;
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc  = cnt + CNT_W'(1);
    assign counting = (state != ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        hit     = 1'b0;
        done    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (run) state_n = (cnt == cmp) ? ST_HOLD : ST_COUNT;
            end
            ST_COUNT: begin
                if (!run) begin
                    state_n = ST_IDLE;
                end else if (tick) begin
                    if (cnt_inc == cmp) begin
                        cnt_n = cmp;
                        hit   = 1'b1;
                        if (oneshot) begin
                            done    = 1'b1;
                            state_n = ST_IDLE;
                        end else begin
                            state_n = ST_HOLD;
                        end
                    end else begin
                        cnt_n = cnt_inc;
                    end
                end
            end
            ST_HOLD: begin
                if (!run) begin
                    state_n = ST_IDLE;
                end else if (tick) begin
                    cnt_n   = '0;
                    state_n = ST_COUNT;
                end
            end
            default: state_n = ST_IDLE;
        endcase
        if (clr) begin
            state_n = ST_IDLE;
            cnt_n   = '0;
            hit     = 1'b0;
            done    = 1'b0;
        end
    end

    // R4: the tick after the hold state returns the counter to zero
    p_hold_wraps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && run && tick && !clr) |=> (cnt == '0));
    // R5: a one-shot completion leaves the machine idle
    p_oneshot_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (state == ST_IDLE));
    // R11: while idle and not started, the counter does not move
    p_idle_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !run && !clr) |=> $stable(cnt));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tick_cmp_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 24,
    parameter int PSC_W   = 7,
    parameter int CMP_MIN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              hit,
    input  logic              done,
    input  logic [CNT_W-1:0]  cnt,
    output logic [DATA_W-1:0] rdata,
    output logic [PSC_W-1:0]  psc_val,
    output logic              run,
    output logic              oneshot,
    output logic              irq_en,
    output logic              clr,
    output logic [CNT_W-1:0]  cmp,
    output logic              flag
);
    localparam logic [CNT_W-1:0] CMP_FLOOR = CNT_W'(CMP_MIN);

    logic             live;
    logic             clr_q;
    logic [CNT_W-1:0] view;
    logic [CNT_W-1:0] wcmp;
    logic             wr_ctrl, wr_cmp, wr_stat;
    logic             unused_wbits;

    assign unused_wbits = ^wdata;
    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign wr_cmp  = wr_en && (addr == A_CMP);
    assign wr_stat = wr_en && (addr == A_STAT);
    assign clr     = wr_ctrl && wdata[B_CLR];
    assign wcmp    = wdata[CNT_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_val <= '0;
            run     <= 1'b0;
            oneshot <= 1'b0;
            irq_en  <= 1'b0;
            live    <= 1'b0;
            clr_q   <= 1'b0;
            cmp     <= '1;
            flag    <= 1'b0;
            view    <= '0;
        end else begin
            clr_q <= clr;
            if (wr_ctrl) begin
                psc_val <= wdata[PSC_W-1:0];
                oneshot <= wdata[B_ONESHOT];
                irq_en  <= wdata[B_IE];
                live    <= wdata[B_LIVE];
                run     <= wdata[B_RUN] && !wdata[B_CLR];
            end else if (done) begin
                run <= 1'b0;
            end
            if (wr_cmp) cmp <= (wcmp < CMP_FLOOR) ? CMP_FLOOR : wcmp;
            if (hit)                      flag <= 1'b1;
            else if (wr_stat && wdata[0]) flag <= 1'b0;
            if (live) view <= cnt;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CTRL: begin
                rdata[PSC_W-1:0] = psc_val;
                rdata[B_RUN]     = run;
                rdata[B_ONESHOT] = oneshot;
                rdata[B_IE]      = irq_en;
                rdata[B_LIVE]    = live;
                rdata[B_CLR]     = clr_q;
            end
            A_CMP:   rdata[CNT_W-1:0] = cmp;
            A_VIEW:  rdata[CNT_W-1:0] = view;
            A_STAT:  rdata[0]         = flag;
            default: rdata = '0;
        endcase
    end

    // R6: the flag only falls after a status write with bit 0 set
    p_flag_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(wr_stat && wdata[0]));
    // R8: the reset indication lasts one cycle unless written again
    p_clr_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_q && !clr) |=> !clr_q);
endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer
    import tick_cmp_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 24,
    parameter int PSC_W   = 7,
    parameter int CMP_MIN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic [PSC_W-1:0] psc_val;
    logic             run, oneshot, irq_en, clr, flag;
    logic             tick, hit, done, counting;
    logic [CNT_W-1:0] cmp, cnt;

    tmr_regs #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W), .CMP_MIN(CMP_MIN)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .hit(hit), .done(done), .cnt(cnt), .rdata(rdata), .psc_val(psc_val),
        .run(run), .oneshot(oneshot), .irq_en(irq_en), .clr(clr),
        .cmp(cmp), .flag(flag)
    );

    tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .clr(clr), .active(counting && run),
        .psc_val(psc_val), .tick(tick)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .clr(clr), .run(run), .oneshot(oneshot),
        .tick(tick), .cmp(cmp), .cnt(cnt), .hit(hit), .done(done),
        .counting(counting)
    );

    assign irq = flag && irq_en;

    // R4: the flag rises only when the counter sits on the compare value
    p_flag_at_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> (cnt == cmp));
    // R8: a counter-reset write leaves the counter at zero and run clear
    p_reset_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!run && cnt == '0));
    // R5: a one-shot completion clears run
    p_oneshot_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(wr_en && addr == A_CTRL)) |=> !run);
endmodule

// File: tb/tick_cmp_timer_test.sv
module tick_cmp_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] A_CTRL = 2'd0, A_CMP = 2'd1, A_VIEW = 2'd2, A_STAT = 2'd3;
    localparam logic [31:0] RUN = 32'h100, ONE = 32'h200, IE = 32'h400,
                            LIVE = 32'h800, CLR = 32'h1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int checks = 0;
    int errors = 0;

    tick_cmp_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // called between a falling and the next rising edge; returns at the falling edge after the write edge
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    function automatic int model_cnt(int j, int p, int c, bit one);
        int k;
        if (j <= 0) return 0;
        k = (j - 1) / (p + 1);
        if (one) return (k > c) ? c : k;
        return k % (c + 1);
    endfunction

    initial begin
        logic [31:0] v;
        int cmps[3] = '{2, 3, 5};
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL, v); check("R1 ctrl", v, 0);
        rd(A_CMP, v);  check("R1 cmp", v, 32'hFFFFFF);
        rd(A_VIEW, v); check("R1 view", v, 0);
        rd(A_STAT, v); check("R1 stat", v, 0);
        check("R1 irq", {31'b0, irq}, 0);

        // R2 compare clamp and width
        wr(A_CMP, 0);            rd(A_CMP, v); check("R2 cmp 0", v, 2);
        wr(A_CMP, 1);            rd(A_CMP, v); check("R2 cmp 1", v, 2);
        wr(A_CMP, 2);            rd(A_CMP, v); check("R2 cmp 2", v, 2);
        wr(A_CMP, 32'h1234567);  rd(A_CMP, v); check("R2 cmp wide", v, 32'h234567);

        // R3 R4 R7 periodic sweep over prescale and compare
        for (int p = 0; p < 4; p++) begin
            for (int ci = 0; ci < 3; ci++) begin
                int c = cmps[ci];
                int n_max = 2 * (c + 1) * (p + 1) + 3;
                wr(A_CTRL, CLR); wr(A_STAT, 1); wr(A_CMP, c);
                wr(A_CTRL, p | RUN | IE | LIVE);
                for (int n = 1; n <= n_max; n++) begin
                    @(negedge clk);
                    rd(A_VIEW, v);
                    check("R3 R4 periodic count", v, model_cnt(n - 1, p, c, 0));
                    check("R4 R7 match irq", {31'b0, irq}, (n >= 1 + c * (p + 1)) ? 1 : 0);
                end
            end
        end

        // R11 stop freezes the counter
        wr(A_CTRL, CLR); wr(A_CMP, 50); wr(A_CTRL, RUN | LIVE);
        for (int n = 1; n <= 9; n++) @(negedge clk);
        wr(A_CTRL, LIVE);
        @(negedge clk); @(negedge clk);
        for (int n = 0; n < 5; n++) begin
            rd(A_VIEW, v); check("R11 frozen", v, 9);
            @(negedge clk);
        end
        rd(A_CTRL, v); check("R11 run clear", v & RUN, 0);

        // R9 view holds while live is clear, then follows
        wr(A_CTRL, CLR);
        wr(A_CTRL, RUN);
        for (int n = 1; n <= 20; n++) begin
            @(negedge clk);
            rd(A_VIEW, v); check("R9 view held", v, 9);
        end
        wr(A_CTRL, RUN | LIVE);
        @(negedge clk);
        rd(A_VIEW, v); check("R9 view live", v, 20);

        // R8 counter reset self-clears
        wr(A_CTRL, CLR | RUN | LIVE);
        rd(A_CTRL, v);
        check("R8 clr bit set", v & CLR, CLR);
        check("R8 run cleared", v & RUN, 0);
        @(negedge clk);
        rd(A_CTRL, v); check("R8 clr bit gone", v & CLR, 0);
        rd(A_VIEW, v); check("R8 counter zero", v, 0);
        for (int n = 0; n < 4; n++) @(negedge clk);
        rd(A_VIEW, v); check("R8 stays zero", v, 0);

        // R6 R7 flag stickiness and irq gating
        wr(A_STAT, 1); wr(A_CMP, 2); wr(A_CTRL, RUN);
        for (int n = 0; n < 5; n++) @(negedge clk);
        rd(A_STAT, v); check("R6 flag set", v, 1);
        check("R7 irq masked", {31'b0, irq}, 0);
        wr(A_CTRL, CLR);
        wr(A_STAT, 0);
        rd(A_STAT, v); check("R6 zero write kept", v, 1);
        wr(A_CTRL, IE);
        check("R7 irq enabled", {31'b0, irq}, 1);
        wr(A_STAT, 1);
        rd(A_STAT, v); check("R6 w1c cleared", v, 0);
        check("R7 irq low", {31'b0, irq}, 0);

        // R5 one-shot
        wr(A_CTRL, CLR); wr(A_STAT, 1); wr(A_CMP, 3);
        wr(A_CTRL, 1 | RUN | ONE | LIVE | IE);
        for (int n = 1; n <= 20; n++) begin
            @(negedge clk);
            rd(A_VIEW, v);
            check("R5 oneshot count", v, model_cnt(n - 1, 1, 3, 1));
            check("R5 oneshot irq", {31'b0, irq}, (n >= 7) ? 1 : 0);
        end
        rd(A_CTRL, v); check("R5 run dropped", v & RUN, 0);
        wr(A_STAT, 1);
        for (int n = 0; n < 10; n++) @(negedge clk);
        rd(A_STAT, v); check("R5 no second match", v, 0);
        rd(A_VIEW, v); check("R5 parked", v, 3);

        // R10 compare rewrite while running keeps prescaler phase
        wr(A_CTRL, CLR); wr(A_STAT, 1); wr(A_CMP, 20);
        wr(A_CTRL, 2 | RUN | IE);
        for (int n = 1; n <= 7; n++) @(negedge clk);
        wr(A_CMP, 4);
        for (int n = 9; n <= 16; n++) begin
            check("R10 rewritten compare", {31'b0, irq}, (n - 1 >= 13) ? 1 : 0);
            @(negedge clk);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule